// File: doc/BRIEF.md
# In-Order Split-Transaction Bus Slave

This block is a memory slave on a split-transaction external bus with a 64-bit data path. A master issues a request as a single-cycle strobe carrying a byte address, a write flag and a burst flag. The block stores each accepted request in a small queue and later runs its data phase, always in the order the requests were accepted. The time between a request and its data can be anything.

Every data cycle is announced by `dvalid`. The data word moves exactly two clocks after that announcement, on `rd_data` for reads and on `wr_data` with active-low byte enables `wr_be_n` for writes. A single request uses one data cycle. A burst request uses four back-to-back data cycles whose word address steps through an aligned 32-byte block and wraps inside it. Because of the fixed two-clock offset, the announcement of a later data cycle can overlap the data of an earlier one. The storage behind the bus is an internal RAM with eight byte lanes. A parameter adds a fixed number of idle clocks before each request's first data cycle.

Top module: `split_bus_slave`

## Requirements
- R1: Data phases complete in exactly the order their requests were accepted. A read queued after a write to the same word returns that write's data. `dvalid` is never asserted while no accepted request has data cycles left.
- R2: For a data cycle whose `dvalid` is high in cycle t, read data is on `rd_data` in cycle t+2, and write data and `wr_be_n` are taken from the bus in cycle t+2.
- R3: A request whose strobe is sampled in cycle N, when the block is otherwise idle, gets its first `dvalid` in cycle N+2+EXTRA_WAIT and never earlier than N+2.
- R4: A burst request (`req_burst`=1) produces four consecutive `dvalid` cycles. Its word index (address bits 3 and up) keeps the upper bits and increments the two low bits modulo 4, so a burst starting at word 10 visits words 10, 11, 8, 9.
- R5: Byte lanes are little-endian. Byte offset k (address bits 2:0 = k) is stored from and returned on bits 8k+7:8k. A byte at offset 3 travels on bits 31:24, and a 32-bit word at offset 4 travels on bits 63:32.
- R6: `wr_be_n` bit k low enables byte lane k of a write. A lane whose bit is high keeps its stored byte, and a write with `wr_be_n`=8'hFF changes nothing.
- R7: Every read returns the full aligned 64-bit word, regardless of the address bits 2:0.
- R8: The queue holds DEPTH requests. `req_ready` is low while it is full. A strobe sampled while `req_ready` is low is dropped, produces no data cycles, and raises `req_overflow` for exactly the next cycle.
- R9: After reset, `req_ready` is high and `dvalid` and `req_overflow` are low.
- R10: When the next request is already queued, its first `dvalid` follows the previous request's last `dvalid` after exactly EXTRA_WAIT idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Request valid for one cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat wrapping burst, 0 = single beat |
| req_ready | output | 1 | Queue can accept a request this cycle |
| req_overflow | output | 1 | One-cycle pulse after a dropped request |
| dvalid | output | 1 | Announces a data cycle two clocks ahead |
| rd_data | output | 64 | Read data, valid two clocks after a read `dvalid` |
| wr_data | input | 64 | Write data, sampled two clocks after a write `dvalid` |
| wr_be_n | input | 8 | Active-low byte enables for write data |

## Verification
A request strobed in cycle N shows its first `dvalid` in cycle N+2+EXTRA_WAIT. The bench notes each request's strobe cycle and each `dvalid` cycle at the falling edge and compares the difference with that figure. A monitor keeps every announced beat in a two-deep delay line. It compares `rd_data` with a byte-lane memory model exactly two falling edges after the `dvalid` that announced the beat, and it drives write data and enables in that same cycle, so a late or early data stage shows up as a mismatch. The spacing between back-to-back requests, the four-beat wrap order, and the overflow pulse one cycle after the dropped strobe are checked at the cycles the requirements give.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  localparam int BUS_BYTES   = 8;
  localparam int LANE_W      = 8;
  localparam int BUS_W       = BUS_BYTES * LANE_W;
  localparam int OFF_BITS    = $clog2(BUS_BYTES);
  localparam int BURST_BEATS = 4;

  typedef struct packed {
    logic valid;
    logic we;
  } beat_ctl_t;
endpackage

// File: rtl/sxb_req_fifo.sv
module sxb_req_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             nonempty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_data = slots[rd_ptr];
  assign nonempty  = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/sxb_beat_seq.sv
module sxb_beat_seq
  import sxb_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int EXTRA_WAIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_valid,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             head_we,
  input  logic             head_burst,
  output logic             launch,
  output logic             dvalid,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_we
);
  localparam int WAIT_W = (EXTRA_WAIT > 0) ? $clog2(EXTRA_WAIT + 1) : 1;
  localparam int REM_W  = $clog2(BURST_BEATS);

  logic [WAIT_W-1:0] wait_cnt;
  logic [REM_W-1:0]  rem;

  assign launch = head_valid && (rem == '0) && (wait_cnt == WAIT_W'(EXTRA_WAIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      dvalid   <= 1'b0;
      beat_idx <= '0;
      beat_we  <= 1'b0;
      rem      <= '0;
      wait_cnt <= '0;
    end else if (launch) begin
      dvalid   <= 1'b1;
      beat_idx <= head_idx;
      beat_we  <= head_we;
      rem      <= head_burst ? REM_W'(BURST_BEATS - 1) : '0;
      wait_cnt <= '0;
    end else if (rem != '0) begin
      dvalid   <= 1'b1;
      beat_idx <= {beat_idx[IDX_W-1:REM_W], beat_idx[REM_W-1:0] + REM_W'(1)};
      rem      <= rem - REM_W'(1);
    end else begin
      dvalid <= 1'b0;
      if (head_valid) wait_cnt <= wait_cnt + WAIT_W'(1);
    end
  end
endmodule

// File: rtl/sxb_data_stage.sv
module sxb_data_stage
  import sxb_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int MEM_WORDS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dvalid,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             beat_we,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [BUS_BYTES-1:0] wr_be_n,
  output logic [BUS_W-1:0] rd_data,
  output logic             wr_fire
);
  beat_ctl_t        ctl1, ctl2;
  logic [IDX_W-1:0] idx1, idx2;
  logic             same_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1 <= '0;
      ctl2 <= '0;
      idx1 <= '0;
      idx2 <= '0;
    end else begin
      ctl1 <= '{valid: dvalid, we: beat_we};
      idx1 <= beat_idx;
      ctl2 <= ctl1;
      idx2 <= idx1;
    end
  end

  assign wr_fire   = ctl2.valid && ctl2.we;
  assign same_word = wr_fire && ctl1.valid && !ctl1.we && (idx1 == idx2);

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [MEM_WORDS];
    logic [LANE_W-1:0] lane_q, fwd_q;
    logic              fwd_sel;

    always_ff @(posedge clk) begin
      if (wr_fire && !wr_be_n[b]) lane_mem[idx2] <= wr_data[b*LANE_W +: LANE_W];
      lane_q <= lane_mem[idx1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        fwd_sel <= 1'b0;
        fwd_q   <= '0;
      end else begin
        fwd_sel <= same_word && !wr_be_n[b];
        fwd_q   <= wr_data[b*LANE_W +: LANE_W];
      end
    end

    assign rd_data[b*LANE_W +: LANE_W] = fwd_sel ? fwd_q : lane_q;
  end
endmodule

// File: rtl/split_bus_slave.sv
module split_bus_slave
  import sxb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH      = 4,
  parameter int EXTRA_WAIT = 2,
  parameter int MEM_WORDS  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_strobe,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 req_burst,
  output logic                 req_ready,
  output logic                 req_overflow,
  output logic                 dvalid,
  output logic [BUS_W-1:0]     rd_data,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic [BUS_BYTES-1:0] wr_be_n
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int ENT_W = IDX_W + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push, fifo_full, head_valid, launch, beat_we, wr_fire;
  logic [ENT_W-1:0] head_ent;
  logic [CNT_W-1:0] fifo_count;
  logic [IDX_W-1:0] beat_idx;
  logic             unused_addr;

  assign unused_addr = ^{req_addr[OFF_BITS-1:0], req_addr[ADDR_W-1:OFF_BITS+IDX_W]};
  assign req_ready   = !fifo_full;
  assign push        = req_strobe && req_ready;

  always_ff @(posedge clk) begin
    if (rst) req_overflow <= 1'b0;
    else     req_overflow <= req_strobe && !req_ready;
  end

  sxb_req_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data ({req_write, req_burst, req_addr[OFF_BITS +: IDX_W]}),
    .pop       (launch),
    .head_data (head_ent),
    .nonempty  (head_valid),
    .full      (fifo_full),
    .count     (fifo_count)
  );

  sxb_beat_seq #(.IDX_W(IDX_W), .EXTRA_WAIT(EXTRA_WAIT)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .head_valid (head_valid),
    .head_idx   (head_ent[IDX_W-1:0]),
    .head_we    (head_ent[IDX_W+1]),
    .head_burst (head_ent[IDX_W]),
    .launch     (launch),
    .dvalid     (dvalid),
    .beat_idx   (beat_idx),
    .beat_we    (beat_we)
  );

  sxb_data_stage #(.IDX_W(IDX_W), .MEM_WORDS(MEM_WORDS)) data_i (
    .clk      (clk),
    .rst      (rst),
    .dvalid   (dvalid),
    .beat_idx (beat_idx),
    .beat_we  (beat_we),
    .wr_data  (wr_data),
    .wr_be_n  (wr_be_n),
    .rd_data  (rd_data),
    .wr_fire  (wr_fire)
  );
endmodule

// File: rtl/split_bus_slave_chk.sv
module split_bus_slave_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_strobe,
  input logic             req_ready,
  input logic             req_overflow,
  input logic             dvalid,
  input logic             launch,
  input logic             launch_burst,
  input logic             wr_fire,
  input logic [CNT_W-1:0] fifo_count
);
  logic [31:0] n_acc, n_acc_d, n_launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_acc    <= '0;
      n_acc_d  <= '0;
      n_launch <= '0;
    end else begin
      if (req_strobe && req_ready) n_acc <= n_acc + 32'd1;
      n_acc_d <= n_acc;
      if (launch) n_launch <= n_launch + 32'd1;
    end
  end

  AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (rst) n_launch <= n_acc_d); // R3
  AST_BURST_RUN: assert property (@(posedge clk) disable iff (rst)
    (launch && launch_burst) |=> dvalid ##1 dvalid ##1 dvalid ##1 dvalid); // R4
  AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (rst) wr_fire |-> $past(dvalid, 2)); // R2
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    (req_strobe && !req_ready) |=> req_overflow); // R8
  AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (rst)
    (!req_strobe || req_ready) |=> !req_overflow); // R8
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst) fifo_count <= CNT_W'(DEPTH)); // R8
endmodule

bind split_bus_slave split_bus_slave_chk #(.DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_strobe   (req_strobe),
  .req_ready    (req_ready),
  .req_overflow (req_overflow),
  .dvalid       (dvalid),
  .launch       (launch),
  .launch_burst (head_ent[IDX_W]),
  .wr_fire      (wr_fire),
  .fifo_count   (fifo_count)
);

// File: tb/split_bus_slave_tb_top.sv
module split_bus_slave_tb_top;
  localparam int E     = 2;
  localparam int WORDS = 64;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_strobe = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, req_overflow, dvalid;
  logic [63:0] rd_data;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be_n = 8'hFF;

  split_bus_slave #(.ADDR_W(16), .DEPTH(4), .EXTRA_WAIT(E), .MEM_WORDS(WORDS)) dut_i (
    .clk(clk), .rst(rst), .req_strobe(req_strobe), .req_addr(req_addr),
    .req_write(req_write), .req_burst(req_burst), .req_ready(req_ready),
    .req_overflow(req_overflow), .dvalid(dvalid), .rd_data(rd_data),
    .wr_data(wr_data), .wr_be_n(wr_be_n));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          idx;
    bit          we;
    logic [63:0] d;
    logic [7:0]  ben;
    int          rid;
    bit          first;
  } beat_t;

  beat_t       bq[$];
  beat_t       s0, s1, cur;
  bit          v0 = 0, v1 = 0, cv;
  logic [63:0] model [WORDS];
  int          req_cyc [64], first_dv [64], last_dv [64], nbeat [64];
  logic [63:0] rd_val [64];
  int          nreq = 0, n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Beat monitor: dvalid at cycle t, data handled at the falling edge of t+2
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        v0 = 0;
        v1 = 0;
      end else begin
        cur = s1; cv = v1;
        s1 = s0;  v1 = v0; v0 = 0;
        if (dvalid) begin
          if (bq.size() == 0) chk(0, "R1", "dvalid with no queued beat", 64'd1, 64'd0);
          else begin
            s0 = bq.pop_front();
            v0 = 1;
            if (s0.first) first_dv[s0.rid] = cyc;
            last_dv[s0.rid] = cyc;
            nbeat[s0.rid]++;
          end
        end
        wr_data = 64'hA5A5_5A5A_F00D_BEEF;
        wr_be_n = 8'h00;
        if (cv) begin
          if (cur.we) begin
            wr_data = cur.d;
            wr_be_n = cur.ben;
            for (int b = 0; b < 8; b++)
              if (!cur.ben[b]) model[cur.idx][8*b +: 8] = cur.d[8*b +: 8];
          end else begin
            chk(rd_data === model[cur.idx], "R2", "read data two clocks after dvalid",
                rd_data, model[cur.idx]);
            rd_val[cur.rid] = rd_data;
          end
        end
      end
    end
  end

  task automatic send(input int baddr, input bit we, input bit burst, input logic [63:0] seed,
                      input logic [7:0] ben, output bit acc, output int rid);
    int idx;
    beat_t b;
    idx        = (baddr >> 3) % WORDS;
    req_strobe = 1'b1;
    req_addr   = 16'(baddr);
    req_write  = we;
    req_burst  = burst;
    acc        = req_ready;
    rid        = nreq;
    if (acc) begin
      req_cyc[rid] = cyc;
      nbeat[rid]   = 0;
      for (int k = 0; k < (burst ? 4 : 1); k++) begin
        b.idx   = (idx & ~3) | ((idx + k) & 3);
        b.we    = we;
        b.d     = seed + 64'(k);
        b.ben   = ben;
        b.rid   = rid;
        b.first = (k == 0);
        bq.push_back(b);
      end
      nreq++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_strobe = 1'b0;
    req_write  = 1'b0;
    req_burst  = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((bq.size() != 0 || v0 || v1) && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
    chk(dvalid === 1'b0, "R9", "dvalid after reset", 64'(dvalid), 64'd0);
    chk(req_overflow === 1'b0, "R9", "overflow after reset", 64'(req_overflow), 64'd0);
  endtask

  task automatic t_single();
    bit a; int rw, rr;
    send(16'h28, 1, 0, 64'h1111_2222_3333_4444, 8'h00, a, rw); idle();
    drain();
    chk(first_dv[rw] - req_cyc[rw] == 2 + E, "R3", "write first dvalid delay",
        64'(first_dv[rw] - req_cyc[rw]), 64'(2 + E));
    send(16'h2D, 0, 0, 64'h0, 8'hFF, a, rr); idle();
    drain();
    chk(first_dv[rr] - req_cyc[rr] == 2 + E, "R3", "read first dvalid delay",
        64'(first_dv[rr] - req_cyc[rr]), 64'(2 + E));
    chk(rd_val[rr] === 64'h1111_2222_3333_4444, "R7", "full word on unaligned read",
        rd_val[rr], 64'h1111_2222_3333_4444);
  endtask

  task automatic t_lanes();
    bit a; int r0, r1, r2, r3, r4, r5;
    send(16'h30, 1, 0, 64'h0706_0504_0302_0100, 8'h00, a, r0);
    send(16'h33, 1, 0, 64'h1234_5678_AA99_8877, 8'hF7, a, r1);
    send(16'h34, 1, 0, 64'hCAFE_BABE_1111_1111, 8'h0F, a, r2);
    send(16'h30, 0, 0, 64'h0, 8'hFF, a, r3); idle();
    drain();
    chk(rd_val[r3] === 64'hCAFE_BABE_AA02_0100, "R5", "byte at offset 3 and word at offset 4",
        rd_val[r3], 64'hCAFE_BABE_AA02_0100);
    send(16'h30, 1, 0, 64'hDEAD_DEAD_DEAD_DEAD, 8'hFF, a, r4);
    send(16'h30, 0, 0, 64'h0, 8'hFF, a, r5); idle();
    drain();
    chk(rd_val[r5] === 64'hCAFE_BABE_AA02_0100, "R6", "all enables high leaves word unchanged",
        rd_val[r5], 64'hCAFE_BABE_AA02_0100);
  endtask

  task automatic t_burst();
    bit a; int rw, r8, r9, r10, r11, rb;
    logic [63:0] s;
    s = 64'h0B00_0000_0000_0000;
    send(16'h50, 1, 1, s, 8'h00, a, rw); idle();
    drain();
    chk(nbeat[rw] == 4 && last_dv[rw] - first_dv[rw] == 3, "R4", "burst beats contiguous",
        64'(last_dv[rw] - first_dv[rw]), 64'd3);
    send(16'h40, 0, 0, 64'h0, 8'hFF, a, r8);
    send(16'h48, 0, 0, 64'h0, 8'hFF, a, r9);
    send(16'h50, 0, 0, 64'h0, 8'hFF, a, r10);
    send(16'h58, 0, 0, 64'h0, 8'hFF, a, r11); idle();
    drain();
    chk(rd_val[r10] === s,     "R4", "wrap word 10 gets beat 0", rd_val[r10], s);
    chk(rd_val[r11] === s + 1, "R4", "wrap word 11 gets beat 1", rd_val[r11], s + 1);
    chk(rd_val[r8]  === s + 2, "R4", "wrap word 8 gets beat 2",  rd_val[r8],  s + 2);
    chk(rd_val[r9]  === s + 3, "R4", "wrap word 9 gets beat 3",  rd_val[r9],  s + 3);
    send(16'h48, 0, 1, 64'h0, 8'hFF, a, rb); idle();
    drain();
    chk(nbeat[rb] == 4 && rd_val[rb] === s + 2, "R4", "read burst from word 9 ends on word 8",
        rd_val[rb], s + 2);
  endtask

  task automatic t_order();
    bit a; int r0, r1, r2, r3;
    send(16'hA0, 1, 0, 64'hAAAA_0000_0000_0001, 8'h00, a, r0);
    send(16'hA0, 0, 0, 64'h0, 8'hFF, a, r1);
    send(16'hA0, 1, 0, 64'hBBBB_0000_0000_0002, 8'h00, a, r2);
    send(16'hA0, 0, 0, 64'h0, 8'hFF, a, r3); idle();
    drain();
    chk(rd_val[r1] === 64'hAAAA_0000_0000_0001, "R1", "first read sees first write",
        rd_val[r1], 64'hAAAA_0000_0000_0001);
    chk(rd_val[r3] === 64'hBBBB_0000_0000_0002, "R1", "second read sees second write",
        rd_val[r3], 64'hBBBB_0000_0000_0002);
    chk(first_dv[r1] == last_dv[r0] + 1 + E, "R10", "gap before queued request 1",
        64'(first_dv[r1]), 64'(last_dv[r0] + 1 + E));
    chk(first_dv[r3] == last_dv[r2] + 1 + E, "R10", "gap before queued request 3",
        64'(first_dv[r3]), 64'(last_dv[r2] + 1 + E));
  endtask

  task automatic t_overflow();
    bit a; int r;
    bit exp_acc [6] = '{1, 1, 1, 1, 1, 0};
    int first_r;
    first_r = nreq;
    for (int i = 0; i < 6; i++) begin
      if (i == 5)
        chk(req_overflow === 1'b0, "R8", "no overflow before drop", 64'(req_overflow), 64'd0);
      send(16'h40, 0, 1, 64'h0, 8'hFF, a, r);
      chk(a == exp_acc[i], "R8", $sformatf("ready at request %0d", i), 64'(a), 64'(exp_acc[i]));
    end
    chk(req_overflow === 1'b1, "R8", "overflow pulse after drop", 64'(req_overflow), 64'd1);
    idle();
    @(negedge clk);
    chk(req_overflow === 1'b0, "R8", "overflow lasts one cycle", 64'(req_overflow), 64'd0);
    drain();
    chk(nreq - first_r == 5 && nbeat[first_r + 4] == 4, "R8", "only accepted requests served",
        64'(nreq - first_r), 64'd5);
    chk(bq.size() == 0, "R1", "all queued beats served", 64'(bq.size()), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_lanes();
    t_burst();
    t_order();
    t_overflow();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule